// File: doc/BRIEF.md
# Sensor Interrupt Controller

This block is the interrupt logic behind a sensor's register interface. It holds a writable interrupt configuration register and a read-only interrupt status register. Two single-cycle event strobes feed it: one for "new sample ready" and one for "clock source ready". Each source has an enable bit. An enabled event sets its status bit. An enabled event also drives an interrupt pin, either held until software clears the status or as a fixed-length pulse.

The pin comes out as a value and an output-enable. Together they give push-pull or open-drain drive at either polarity. The block watches a plain register read port to clear the status. Depending on configuration, the clear happens on a read of any address or only on a read of the status register. The serial bus, the sample registers and the clock source live outside this block.

Top module: `sens_irq_ctrl`

## Requirements
- R1: After reset, the configuration (address 0x17) and the status (address 0x1A) both read 0x00. The pin is then inactive in push-pull active-high form: `irq_o`=0 and `irq_oe`=1.
- R2: A write to 0x17 stores the data masked with 0xF5, so bits 3 and 1 always read 0. Writes to 0x1A, or to any other address, change nothing.
- R3: Status bit 0 is set by an `evt_data` strobe when configuration bit 0 is 1. Status bit 2 is set by an `evt_ready` strobe when configuration bit 2 is 1. All other status bits read 0.
- R4: An event whose enable bit is 0 sets no status bit and produces no pin activity.
- R5: With configuration bit 5 = 1 (latch), the pin stays active for as long as any status bit is set.
- R6: With configuration bit 5 = 0 (pulse), each enabled event makes the pin active for exactly round(CLK_HZ × 50 µs) cycles. An enabled event during a pulse restarts the full count. The status bits are not touched when the pulse ends.
- R7: With configuration bit 4 = 1, a read of any address clears the status.
- R8: With configuration bit 4 = 0, only a read of 0x1A clears the status. A read of another address leaves both the status and the pin unchanged.
- R9: A clearing read returns the status value held before the clear. The clear takes effect on the following cycle.
- R10: If an enabled event and a clearing read fall in the same cycle, the event wins: its status bit ends up set and the pin is active.
- R11: Configuration bit 7 = 1 makes the pin active-low, and bit 7 = 0 makes it active-high. Neither polarity nor latch mode changes the status bits.
- R12: With configuration bit 6 = 1 (open drain), `irq_o` is 0 and `irq_oe` is 1 only while the pin level must be low; otherwise the pin is released. With bit 6 = 0 (push-pull), `irq_oe` is always 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read data, valid in the same cycle as `rd_en` |
| evt_data | input | 1 | Single-cycle new-sample event |
| evt_ready | input | 1 | Single-cycle clock-ready event |
| irq_o | output | 1 | Interrupt pin output value |
| irq_oe | output | 1 | Interrupt pin output enable |

## Verification
The hardest situation to reach is the collision between an enabled event and a clearing read in the same clock cycle. Sequential bus tasks never produce it. The bench therefore raises the read strobe and the event strobe together on one falling edge, then confirms that the status read afterwards still holds the event's bit and that the pin stays active. The pulse restart is reached in a similar way. A second event is timed to land mid-pulse, and the bench counts the active cycles that follow, which tells a reloaded counter apart from one that is left running.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

   // Configuration register layout (bit order is decoded by the logic below)
   typedef struct packed {
      logic act_low;   // 7: pin active level is low
      logic open_drn;  // 6: open-drain drive
      logic latch;     // 5: hold until cleared
      logic any_clr;   // 4: any read clears status
      logic rsv3;      // 3: always zero
      logic rdy_en;    // 2: clock-ready source enable
      logic rsv1;      // 1: always zero
      logic dat_en;    // 0: new-sample source enable
   } sirq_cfg_t;

   localparam logic [7:0] SIRQ_CFG_WMASK = 8'hF5;
   localparam int         SIRQ_NSRC      = 2;

endpackage

// File: rtl/sirq_cfg_reg.sv
module sirq_cfg_reg
   import sirq_pkg::*;
#(
   parameter int                ADDR_W   = 8,
   parameter logic [ADDR_W-1:0] CFG_ADDR = 'h17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   output sirq_cfg_t         cfg
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cfg <= '0;
      else if (wr_en && (wr_addr == CFG_ADDR))
         cfg <= sirq_cfg_t'(wr_data & SIRQ_CFG_WMASK);
   end

endmodule

// File: rtl/sirq_status.sv
module sirq_status #(
   parameter int NSRC = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] evt,
   input  logic [NSRC-1:0] en,
   input  logic            clr,
   output logic [NSRC-1:0] stat,
   output logic            trig
);

   logic [NSRC-1:0] fire;

   assign fire = evt & en;
   assign trig = |fire;

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            stat[i] <= 1'b0;
         else if (fire[i])
            stat[i] <= 1'b1;     // event has priority over a clear
         else if (clr)
            stat[i] <= 1'b0;
      end
   end

endmodule

// File: rtl/sirq_pulse.sv
module sirq_pulse #(
   parameter int PULSE_CYC = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   input  logic latch,
   input  logic stat_any,
   output logic active
);

   logic pulse_on;

   if (PULSE_CYC == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pulse_on <= 1'b0;
         else        pulse_on <= trig;
      end
   end else begin : g_count
      localparam int CW = $clog2(PULSE_CYC + 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cnt <= '0;
         else if (trig)
            cnt <= CW'(PULSE_CYC);
         else if (cnt != '0)
            cnt <= cnt - 1'b1;
      end
      assign pulse_on = (cnt != '0);
   end

   assign active = latch ? stat_any : pulse_on;

endmodule

// File: rtl/sirq_pad.sv
module sirq_pad (
   input  logic active,
   input  logic act_low,
   input  logic open_drn,
   output logic pin_o,
   output logic pin_oe
);

   logic level;

   always_comb begin
      level = active ^ act_low;
      if (open_drn) begin
         pin_o  = 1'b0;
         pin_oe = ~level;
      end else begin
         pin_o  = level;
         pin_oe = 1'b1;
      end
   end

endmodule

// File: rtl/sens_irq_ctrl.sv
module sens_irq_ctrl
   import sirq_pkg::*;
#(
   parameter int                ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] CFG_ADDR  = 'h17,
   parameter logic [ADDR_W-1:0] STAT_ADDR = 'h1A,
   parameter int                CLK_HZ    = 200_000_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   input  logic              evt_data,
   input  logic              evt_ready,
   output logic              irq_o,
   output logic              irq_oe
);

   localparam longint PULSE_L   = (longint'(CLK_HZ) * 50 + 500_000) / 1_000_000;
   localparam int     PULSE_CYC = int'(PULSE_L);

   if (ADDR_W < 5) begin : g_bad_addr
      $error("sens_irq_ctrl: ADDR_W too small for register map");
   end
   if (PULSE_CYC < 1) begin : g_bad_clk
      $error("sens_irq_ctrl: CLK_HZ gives a pulse shorter than one cycle");
   end
   if (CFG_ADDR == STAT_ADDR) begin : g_bad_map
      $error("sens_irq_ctrl: register addresses collide");
   end

   sirq_cfg_t              cfg_q;
   logic [SIRQ_NSRC-1:0]   stat_q;
   logic                   trig;
   logic                   clr;
   logic                   active;

   sirq_cfg_reg #(.ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .cfg     (cfg_q)
   );

   assign clr = rd_en && (cfg_q.any_clr || (rd_addr == STAT_ADDR));

   sirq_status #(.NSRC(SIRQ_NSRC)) u_stat (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   ({evt_ready, evt_data}),
      .en    ({cfg_q.rdy_en, cfg_q.dat_en}),
      .clr   (clr),
      .stat  (stat_q),
      .trig  (trig)
   );

   sirq_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
      .clk      (clk),
      .rst_n    (rst_n),
      .trig     (trig),
      .latch    (cfg_q.latch),
      .stat_any (|stat_q),
      .active   (active)
   );

   sirq_pad u_pad (
      .active   (active),
      .act_low  (cfg_q.act_low),
      .open_drn (cfg_q.open_drn),
      .pin_o    (irq_o),
      .pin_oe   (irq_oe)
   );

   always_comb begin
      if (rd_addr == CFG_ADDR)
         rd_data = cfg_q;
      else if (rd_addr == STAT_ADDR)
         rd_data = {5'b0, stat_q[1], 1'b0, stat_q[0]};
      else
         rd_data = 8'h00;
   end

endmodule

// File: rtl/sirq_checker.sv
module sirq_checker (
   input logic       clk,
   input logic       rst_n,
   input logic [7:0] cfg,
   input logic [1:0] stat,
   input logic       evt_data,
   input logic       evt_ready,
   input logic       rd_en,
   input logic       irq_o,
   input logic       irq_oe
);

   logic pin_level;
   assign pin_level = cfg[6] ? ~irq_oe : irq_o;

   assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg[0] && !stat[0]) |=> !stat[0]);

   assert_event_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_data && cfg[0]) |=> stat[0]);

   assert_any_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && cfg[4] && !(evt_data && cfg[0]) && !(evt_ready && cfg[2])) |=> (stat == 2'b00));

   assert_push_pull_oe_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg[6] |-> irq_oe);

   assert_open_drain_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
      cfg[6] |-> !irq_o);

   assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[5] && (stat != 2'b00)) |-> (pin_level == ~cfg[7]));

endmodule

bind sens_irq_ctrl sirq_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg       (cfg_q),
   .stat      (stat_q),
   .evt_data  (evt_data),
   .evt_ready (evt_ready),
   .rd_en     (rd_en),
   .irq_o     (irq_o),
   .irq_oe    (irq_oe)
);

// File: tb/sens_irq_ctrl_test.sv
`timescale 1ns/1ps
module sens_irq_ctrl_test;

   localparam int PULSE = 10;   // CLK_HZ 200 kHz -> 10 cycles

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0, rd_en = 1'b0, evt_data = 1'b0, evt_ready = 1'b0;
   logic [7:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
   logic [7:0] rd_data;
   logic       irq_o, irq_oe;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   sens_irq_ctrl #(.CLK_HZ(200_000)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .evt_data(evt_data), .evt_ready(evt_ready), .irq_o(irq_o), .irq_oe(irq_oe)
   );

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk); #1;
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; #1;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = a;
      #1 d = rd_data;
      @(negedge clk);
      rd_en = 1'b0; #1;
   endtask

   task automatic fire(input bit dat, input bit rdy);
      @(negedge clk);
      evt_data = dat; evt_ready = rdy;
      @(negedge clk);
      evt_data = 1'b0; evt_ready = 1'b0; #1;
   endtask

   task automatic count_active(output int c);
      c = 0;
      while (irq_o && c < 60) begin
         c++;
         step();
      end
   endtask

   task automatic t_reset();
      logic [7:0] d;
      rd(8'h17, d); check("R1 cfg", d, 8'h00);
      rd(8'h1A, d); check("R1 status", d, 8'h00);
      check("R1 irq_o", irq_o, 0);
      check("R1 irq_oe", irq_oe, 1);
   endtask

   task automatic t_cfg_write();
      logic [7:0] d;
      wr(8'h17, 8'hFF);
      rd(8'h17, d); check("R2 masked write", d, 8'hF5);
      wr(8'h17, 8'h00);
      wr(8'h1A, 8'hFF);
      rd(8'h1A, d); check("R2 status write ignored", d, 8'h00);
      wr(8'h05, 8'hFF);
      rd(8'h17, d); check("R2 other write ignored", d, 8'h00);
   endtask

   task automatic t_disabled();
      logic [7:0] d;
      wr(8'h17, 8'h20);          // latch, both sources off
      fire(1, 1);
      check("R4 pin quiet", irq_o, 0);
      rd(8'h1A, d); check("R4 status clear", d, 8'h00);
   endtask

   task automatic t_latch();
      logic [7:0] d;
      wr(8'h17, 8'h25);
      fire(1, 0);
      repeat (3 * PULSE) step();
      check("R5 latched pin", irq_o, 1);
      rd(8'h17, d); check("R8 cfg read value", d, 8'h25);
      check("R8 pin after other read", irq_o, 1);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = 8'h1A;
      #1 check("R9 pre-clear value", rd_data, 8'h01);
      check("R9 pin still set during read", irq_o, 1);
      @(negedge clk);
      rd_en = 1'b0; #1;
      check("R9 pin cleared next cycle", irq_o, 0);
      rd(8'h1A, d); check("R9 status after clear", d, 8'h00);
      fire(0, 1);
      rd(8'h1A, d); check("R3 ready bit position", d, 8'h04);
      fire(1, 1);
      rd(8'h1A, d); check("R3 both bits", d, 8'h05);
   endtask

   task automatic t_anyread();
      logic [7:0] d;
      wr(8'h17, 8'h35);
      fire(1, 0);
      check("R7 pin set", irq_o, 1);
      rd(8'h03, d);
      check("R7 pin cleared by any read", irq_o, 0);
      wr(8'h17, 8'h25);
      rd(8'h1A, d); check("R7 status cleared", d, 8'h00);
   endtask

   task automatic t_pulse();
      logic [7:0] d;
      int c;
      wr(8'h17, 8'h01);
      fire(1, 0);
      count_active(c); check("R6 pulse width", c, PULSE);
      rd(8'h1A, d); check("R6 status survives pulse", d, 8'h01);
      fire(1, 0);
      repeat (5) step();
      fire(1, 0);
      count_active(c); check("R6 restart full width", c, PULSE);
      rd(8'h1A, d);
   endtask

   task automatic t_collide();
      logic [7:0] d;
      wr(8'h17, 8'h25);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = 8'h1A; evt_data = 1'b1;
      @(negedge clk);
      rd_en = 1'b0; evt_data = 1'b0; #1;
      check("R10 pin after collision", irq_o, 1);
      rd(8'h1A, d); check("R10 status kept", d, 8'h01);
   endtask

   task automatic t_polarity();
      logic [7:0] d;
      wr(8'h17, 8'hA5);
      check("R11 idle active-low", irq_o, 1);
      fire(1, 0);
      check("R11 asserted low", irq_o, 0);
      rd(8'h1A, d); check("R11 status unaffected", d, 8'h01);
      check("R11 released high", irq_o, 1);
   endtask

   task automatic t_open_drain();
      logic [7:0] d;
      wr(8'h17, 8'hE5);          // open drain, active low
      check("R12 od idle released", irq_oe, 0);
      fire(1, 0);
      check("R12 od drives", irq_oe, 1);
      check("R12 od value low", irq_o, 0);
      rd(8'h1A, d);
      wr(8'h17, 8'h65);          // open drain, active high
      check("R12 od idle pulls low", irq_oe, 1);
      fire(0, 0);
      wr(8'h17, 8'h64);
      fire(1, 0);
      check("R4 od disabled source", irq_oe, 1);
      wr(8'h17, 8'h65);
      fire(1, 0);
      check("R12 od active released", irq_oe, 0);
      rd(8'h1A, d);
      wr(8'h17, 8'h00);
      check("R12 push-pull oe", irq_oe, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step();
      t_reset();
      t_cfg_write();
      t_disabled();
      t_latch();
      t_anyread();
      t_pulse();
      t_collide();
      t_polarity();
      t_open_drain();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      #(5.0 * 100_000);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule